// File: doc/BRIEF.md
# Input Change Interrupt for a Two-Port GPIO Expander

This block watches the general-purpose pins of an I/O expander and requests the host's attention whenever a pin that is set up as an input no longer matches the level last captured for it. Each 8-bit port keeps its own snapshot of the pin levels. Pins are brought into the clock domain through a synchronizer. The synchronized levels are then compared bit by bit against the snapshot. Any difference on an input-direction pin raises the request.

The request is level-based and is not latched on edges. If the pin returns to its captured level, the request goes away by itself. A read of a port's input register also clears it, because the read strobe reloads that port's snapshot from the current synchronized pins. The two ports are independent: a read of one port never touches the snapshot of the other.

The output is one enable for an open-drain pad. When the enable is high, the pad pulls the shared line low, which gives an active-low interrupt.

Top module: `ioc_change_irq`

## Requirements
- R1: While `rst` is high the snapshots load the synchronized pins and `irq_pull_o` is 0. With pins held steady, `irq_pull_o` stays 0 after reset.
- R2: Pin bit `p*PW+i` belongs to port `p`, bit `i`. When an input-direction pin changes, `irq_pull_o` goes to 1 on the third rising edge after the change: two synchronizer edges, then one output-register edge.
- R3: A pin whose `dir_in_i` bit is 0 (output direction) never makes `irq_pull_o` high, however its level changes.
- R4: When every differing input pin returns to its snapshot level, `irq_pull_o` returns to 0 with the same three-edge latency.
- R5: A pulse on `port_rd_i[p]` loads port `p`'s snapshot from its synchronized pins at that edge. If no other mismatch exists, `irq_pull_o` falls at the following edge.
- R6: A read of one port leaves the other port's snapshot unchanged. A mismatch on port 1 survives a read of port 0, and the reverse also holds.
- R7: If a differing pin is switched from output to input (its `dir_in_i` bit goes from 0 to 1), `irq_pull_o` rises at the next edge. This is not masked.
- R8: When a read strobe meets the edge at which a new pin level first reaches the synchronizer output, the snapshot takes the older level. The request is then raised at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_level_i | input | NP*PW (16) | Raw pin levels, port p in bits p*PW+PW-1 .. p*PW |
| dir_in_i | input | NP*PW (16) | Direction per pin: 1 input, 0 output |
| port_rd_i | input | NP (2) | One-cycle strobe per port marking a read of its input register |
| irq_pull_o | output | 1 | Open-drain pull enable; 1 drives the interrupt line low |

## Verification
The risky overlap is a port read landing on the same edge at which a fresh pin level leaves the synchronizer. Refreshing the snapshot and detecting a new difference then happen together, and the change must not be lost. The bench provokes this directly by timing the read strobe one cycle after a pin flip. It expects the request to rise one edge later. The random phase throws reads, pin flips and direction changes at the block together, and each cycle it compares against a bench model built from the requirements.

// File: rtl/ioc_pkg.sv
package ioc_pkg;

    typedef enum logic {
        DIR_OUT = 1'b0,
        DIR_IN  = 1'b1
    } pin_dir_e;

    // Bits that are input-direction and differ from their snapshot.
    function automatic logic [7:0] diff_in8(input logic [7:0] live,
                                            input logic [7:0] snap,
                                            input logic [7:0] dir);
        return (live ^ snap) & dir;
    endfunction

endpackage

// File: rtl/ioc_sync.sv
module ioc_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        stg[0] <= d;
        for (int k = 1; k < STAGES; k++) begin
            stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ioc_port_snap.sv
module ioc_port_snap #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd,
    input  logic [PW-1:0] live,
    input  logic [PW-1:0] dir,
    output logic [PW-1:0] snap,
    output logic          differs
);
    always_ff @(posedge clk) begin
        if (rst || rd) begin
            snap <= live;
        end
    end

    assign differs = |((live ^ snap) & dir);
endmodule

// File: rtl/ioc_irq_reduce.sv
module ioc_irq_reduce #(
    parameter int NP = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NP-1:0] port_diff,
    output logic          pull
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pull <= 1'b0;
        end else begin
            pull <= |port_diff;
        end
    end
endmodule

// File: rtl/ioc_change_irq.sv
module ioc_change_irq #(
    parameter int NP          = 2,
    parameter int PW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NP*PW-1:0] pin_level_i,
    input  logic [NP*PW-1:0] dir_in_i,
    input  logic [NP-1:0]    port_rd_i,
    output logic             irq_pull_o
);
    localparam int NBITS = NP * PW;

    logic [NBITS-1:0] pin_sync;
    logic [NBITS-1:0] snap_flat;
    logic [NP-1:0]    port_diff;

    ioc_sync #(.W(NBITS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (pin_level_i),
        .q   (pin_sync)
    );

    for (genvar p = 0; p < NP; p++) begin : g_port
        ioc_port_snap #(.PW(PW)) u_snap (
            .clk     (clk),
            .rst     (rst),
            .rd      (port_rd_i[p]),
            .live    (pin_sync[p*PW +: PW]),
            .dir     (dir_in_i[p*PW +: PW]),
            .snap    (snap_flat[p*PW +: PW]),
            .differs (port_diff[p])
        );
    end

    ioc_irq_reduce #(.NP(NP)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .port_diff (port_diff),
        .pull      (irq_pull_o)
    );
endmodule

// File: rtl/ioc_change_irq_chk.sv
module ioc_change_irq_chk #(
    parameter int NP = 2,
    parameter int PW = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [NP*PW-1:0] pin_sync,
    input logic [NP*PW-1:0] snap_flat,
    input logic [NP*PW-1:0] dir_in_i,
    input logic [NP-1:0]    port_rd_i,
    input logic             irq_pull_o
);
    logic rst_q = 1'b0;
    always_ff @(posedge clk) rst_q <= rst;

    always @(posedge clk) begin
        if (rst_q) begin
            AST_RESET_QUIET: assert (!irq_pull_o); // R1
        end
    end

    AST_IRQ_TRACKS_DIFF: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq_pull_o == $past(|((pin_sync ^ snap_flat) & dir_in_i)))); // R2

    AST_OUTPUT_PINS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!rst && dir_in_i == '0) |=> !irq_pull_o); // R3

    for (genvar p = 0; p < NP; p++) begin : g_chk
        AST_READ_REFRESH: assert property (@(posedge clk) disable iff (rst)
            (port_rd_i[p] && !rst) |=> (snap_flat[p*PW +: PW] == $past(pin_sync[p*PW +: PW]))); // R5
        AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!port_rd_i[p] && !rst) |=> $stable(snap_flat[p*PW +: PW])); // R6
    end
endmodule

bind ioc_change_irq ioc_change_irq_chk #(.NP(NP), .PW(PW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pin_sync   (pin_sync),
    .snap_flat  (snap_flat),
    .dir_in_i   (dir_in_i),
    .port_rd_i  (port_rd_i),
    .irq_pull_o (irq_pull_o)
);

// File: tb/tb_ioc_change_irq.sv
module tb_ioc_change_irq;
    localparam int NP = 2;
    localparam int PW = 8;
    localparam int NB = NP * PW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NB-1:0] pins = 16'h5A3C;
    logic [NB-1:0] dir  = '1;
    logic [NP-1:0] rd   = '0;
    logic          irq;

    int n_cmp  = 0;
    int n_bad  = 0;
    int cycles = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ioc_change_irq dut (
        .clk         (clk),
        .rst         (rst),
        .pin_level_i (pins),
        .dir_in_i    (dir),
        .port_rd_i   (rd),
        .irq_pull_o  (irq)
    );

    // Reference model built from the requirements.
    logic [NB-1:0] m_s1, m_s2, m_snap;
    logic          m_irq;

    function automatic logic expect_irq(input logic [NB-1:0] live,
                                        input logic [NB-1:0] snap,
                                        input logic [NB-1:0] d);
        return |((live ^ snap) & d);
    endfunction

    always @(posedge clk) begin
        m_s1 <= pins;
        m_s2 <= m_s1;
        if (rst) begin
            m_snap <= m_s2;
            m_irq  <= 1'b0;
        end else begin
            for (int p = 0; p < NP; p++)
                if (rd[p]) m_snap[p*PW +: PW] <= m_s2[p*PW +: PW];
            m_irq <= expect_irq(m_s2, m_snap, dir);
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: irq_pull_o actual %0b expected %0b at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run actual hung expected finished");
            finish_run();
        end
    end

    always @(negedge clk) begin
        if (model_on) chk("R2 model", irq, m_irq);
    end

    initial begin
        step(6);
        rst = 1'b0;
        step(2);
        chk("R1", irq, 1'b0);

        // R2 latency and R4 self-clear
        pins[3] = ~pins[3];
        step(2); chk("R2 not yet", irq, 1'b0);
        step(1); chk("R2", irq, 1'b1);
        pins[3] = ~pins[3];
        step(2); chk("R4 not yet", irq, 1'b1);
        step(1); chk("R4", irq, 1'b0);

        // R5 read clears
        pins[3] = ~pins[3];
        step(3); chk("R5 raised", irq, 1'b1);
        rd = 2'b01; step(1); rd = 2'b00;
        chk("R5 same edge", irq, 1'b1);
        step(1); chk("R5", irq, 1'b0);

        // R6 port independence
        pins[10] = ~pins[10];
        step(3); chk("R6 raised", irq, 1'b1);
        rd = 2'b01; step(1); rd = 2'b00;
        step(2); chk("R6 port0 read keeps", irq, 1'b1);
        pins[1] = ~pins[1];
        rd = 2'b10; step(1); rd = 2'b00;
        step(2); chk("R6 port1 read keeps port0", irq, 1'b1);
        rd = 2'b01; step(1); rd = 2'b00;
        step(1); chk("R6 cleared", irq, 1'b0);

        // R3 outputs ignored, then R7 false interrupt on turn-around
        dir[7:0] = 8'h00;
        pins[2] = ~pins[2];
        pins[6] = ~pins[6];
        step(4); chk("R3", irq, 1'b0);
        dir[7:0] = 8'hFF;
        step(1); chk("R7", irq, 1'b1);
        rd = 2'b01; step(1); rd = 2'b00;
        step(1); chk("R7 cleared", irq, 1'b0);

        // R8 read collides with arrival of new level
        pins[13] = ~pins[13];
        step(1);
        rd = 2'b10; step(1); rd = 2'b00;
        step(1); chk("R8", irq, 1'b1);
        rd = 2'b10; step(1); rd = 2'b00;
        step(1); chk("R8 cleared", irq, 1'b0);

        // Random phase against the model
        void'($urandom(32'd7319));
        model_on = 1'b1;
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(3) == 0) pins[$urandom_range(NB-1)] ^= 1'b1;
            if ($urandom_range(15) == 0) dir[$urandom_range(NB-1)] ^= 1'b1;
            rd = 2'(($urandom_range(5) == 0) ? $urandom_range(3) : 0);
            step(1);
        end
        rd = '0;
        model_on = 1'b0;

        // R1 again: reset with a pending mismatch
        pins[0] = ~pins[0];
        dir = '1;
        rst = 1'b1;
        step(5);
        rst = 1'b0;
        step(1); chk("R1 reset clears", irq, 1'b0);
        step(3); chk("R1 stays low", irq, 1'b0);

        done = 1'b1;
        finish_run();
    end
endmodule